// File: doc/BRIEF.md
# Soft-Error-Tolerant Cache Tag Array with Replica Buffer

This block holds the tag array of a set-associative L1 data cache and keeps each stored tag under even parity. Next to it sits a small fully associative replica buffer. Each replica entry records a copy of one tag and the set and way that tag belongs to. Every tag entry carries a copy flag that tells whether a replica currently exists. On a lookup, the block checks the parity of every valid way in the addressed set. If a way shows a parity error and has a replica, the way is rebuilt from that replica and the access goes on. If a way shows a parity error and has no replica, the access is reported as unrecoverable and nothing is changed.

Replicas are made on demand. A tag that is accessed and has no replica gets one. Depending on the mode, this happens for every line or only for dirty lines. When the buffer is full, a slot is chosen for reuse: a free slot first, and otherwise the oldest slot in rotation. In the write-back mode, the line whose replica is pushed out is sent to the next level and marked clean, so no dirty tag is ever left without a replica.

The block accepts one request at a time through a two-state controller. The states are IDLE, which accepts a request (IDLE to EVAL when a request is offered, otherwise stay), and EVAL, which checks, repairs, updates and responds (EVAL always returns to IDLE). A separate injection port flips chosen bits of a stored tag, so that soft errors can be modelled.

Top module: `tag_guard_array`

## Requirements
- R1: req_ready is high in IDLE. A request taken on a clock edge with req_valid and req_ready high drops req_ready for one cycle. rsp_valid is high for exactly one cycle, starting at the second edge after acceptance.
- R2: req_op encodes 0 = load, 1 = store, 2 = fill (write tag req_tag with dirty flag req_dirty into set req_set, way req_way), 3 = invalidate. A load or store sets rsp_hit, and gives the matching way on rsp_way, when a valid way of req_set holds req_tag. Otherwise rsp_hit is 0. A store hit marks the line dirty.
- R3: A single-bit error in a stored tag (injected through inj_en/inj_set/inj_way/inj_mask) whose entry has a replica is repaired on the next lookup of that set. That lookup raises rsp_fixed and hits on the restored tag, and a later lookup hits with rsp_fixed low.
- R4: A parity error in a valid way that has no replica raises rsp_uncorr for that response and forces rsp_hit to 0. No state changes, so the same lookup repeated reports rsp_uncorr again.
- R5: mode encodes 0 = replicate every accessed line, 1 = replicate dirty lines only, 2 or 3 = dirty lines only with forced write-back. In mode 0, a fill or a hitting lookup of a line without a replica creates one.
- R6: In modes 1 to 3, a clean line gets no replica. A store hit that makes a line dirty creates its replica in the same cycle.
- R7: A fill or an invalidate of a way removes any replica of the tag that way held before, and clears its copy flag in the same cycle. An invalidated way no longer hits.
- R8: A new replica goes into the lowest-numbered free slot. When no slot is free, it goes into the slot named by a rotating pointer that starts at 0 and advances by one on each such reuse. The displaced line loses its copy flag.
- R9: In modes 2 and 3, displacing a replica raises wb_req for one cycle, together with rsp_valid, with the displaced line's set on wb_set and its way on wb_way, and clears that line's dirty flag. In modes 0 and 1, wb_req stays low.
- R10: One lookup may repair one way of a set while it creates a replica for the hitting way of the same set and displaces a third line. All three effects happen in the same response cycle.
- R11: rsp_fixed and rsp_uncorr are never high together. rsp_hit, rsp_fixed, rsp_uncorr and wb_req are only high while rsp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Replication mode, sampled in EVAL |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller is in IDLE |
| req_op | input | 2 | Operation code |
| req_set | input | SET_W | Set index |
| req_way | input | WAY_W | Way for fill and invalidate |
| req_tag | input | TAG_W | Tag to compare or write |
| req_dirty | input | 1 | Dirty flag written by a fill |
| inj_en | input | 1 | Flip bits of one stored tag this cycle |
| inj_set | input | SET_W | Set of the injected tag |
| inj_way | input | WAY_W | Way of the injected tag |
| inj_mask | input | TAG_W | Bits to flip |
| rsp_valid | output | 1 | Response cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Hitting way |
| rsp_fixed | output | 1 | A tag was restored from its replica |
| rsp_uncorr | output | 1 | Parity error without replica |
| wb_req | output | 1 | Forced write-back of a displaced line |
| wb_set | output | SET_W | Set of that line |
| wb_way | output | WAY_W | Way of that line |

## Verification
The case that matters most is a store in which tag repair and replica creation with displacement fall in the same cycle. The bench fills the replica buffer with dirty lines in write-back mode and places a clean line in a set whose other way holds a replica. It then corrupts that other way and issues a store to the clean line. The single response must show the hit way, rsp_fixed, and a write-back of the line at the rotation pointer. A follow-up lookup of the repaired way must hit cleanly, which shows the repair was written even though a displacement happened in the same cycle.

// File: rtl/tgr_pkg.sv
package tgr_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FILL  = 2'd2,
        OP_INVAL = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RM_ALL      = 2'd0,
        RM_DIRTY    = 2'd1,
        RM_DIRTY_WB = 2'd2,
        RM_DIRTY_W2 = 2'd3
    } rmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } state_e;

endpackage

// File: rtl/tgr_tag_store.sv
module tgr_tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int SET_W = 4,
    parameter int WAY_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]            rd_par,
    output logic [WAYS-1:0]            rd_vld,
    output logic [WAYS-1:0]            rd_dty,
    output logic [WAYS-1:0]            rd_cpy,
    input  logic                       ln_en,
    input  logic [WAY_W-1:0]           ln_way,
    input  logic [TAG_W-1:0]           ln_tag,
    input  logic                       ln_vld,
    input  logic                       ln_dty,
    input  logic                       ln_cpy,
    input  logic [WAYS-1:0]            fix_en,
    input  logic [WAYS-1:0][TAG_W-1:0] fix_tag,
    input  logic                       dset_en,
    input  logic                       cset_en,
    input  logic [WAY_W-1:0]           hit_way,
    input  logic                       vic_en,
    input  logic                       vic_clr_dty,
    input  logic [SET_W-1:0]           vic_set,
    input  logic [WAY_W-1:0]           vic_way,
    input  logic                       inj_en,
    input  logic [SET_W-1:0]           inj_set,
    input  logic [WAY_W-1:0]           inj_way,
    input  logic [TAG_W-1:0]           inj_mask
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic             par_q [SETS][WAYS];
    logic             vld_q [SETS][WAYS];
    logic             dty_q [SETS][WAYS];
    logic             cpy_q [SETS][WAYS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w] = tag_q[rd_set][w];
            rd_par[w] = par_q[rd_set][w];
            rd_vld[w] = vld_q[rd_set][w];
            rd_dty[w] = dty_q[rd_set][w];
            rd_cpy[w] = cpy_q[rd_set][w];
        end
    end

    // Later statements win; the controller never aims two writes at one field.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    par_q[s][w] <= 1'b0;
                    vld_q[s][w] <= 1'b0;
                    dty_q[s][w] <= 1'b0;
                    cpy_q[s][w] <= 1'b0;
                end
            end
        end else begin
            if (vic_en) begin
                cpy_q[vic_set][vic_way] <= 1'b0;
                if (vic_clr_dty) dty_q[vic_set][vic_way] <= 1'b0;
            end
            if (ln_en) begin
                tag_q[rd_set][ln_way] <= ln_tag;
                par_q[rd_set][ln_way] <= ^ln_tag;
                vld_q[rd_set][ln_way] <= ln_vld;
                dty_q[rd_set][ln_way] <= ln_dty;
                cpy_q[rd_set][ln_way] <= ln_cpy;
            end
            for (int w = 0; w < WAYS; w++) begin
                if (fix_en[w]) begin
                    tag_q[rd_set][w] <= fix_tag[w];
                    par_q[rd_set][w] <= ^fix_tag[w];
                end
            end
            if (dset_en) dty_q[rd_set][hit_way] <= 1'b1;
            if (cset_en) cpy_q[rd_set][hit_way] <= 1'b1;
            if (inj_en)  tag_q[inj_set][inj_way] <= tag_q[inj_set][inj_way] ^ inj_mask;
        end
    end
endmodule

// File: rtl/tgr_replica_buf.sv
module tgr_replica_buf #(
    parameter int DEPTH = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int SET_W = 4,
    parameter int WAY_W = 2,
    parameter int IDX_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           qry_set,
    output logic [WAYS-1:0]            q_hit,
    output logic [WAYS-1:0][IDX_W-1:0] q_idx,
    output logic [WAYS-1:0][TAG_W-1:0] q_tag,
    output logic                       vic_valid,
    output logic [SET_W-1:0]           vic_set,
    output logic [WAY_W-1:0]           vic_way,
    input  logic                       put_en,
    input  logic                       put_inplace,
    input  logic [IDX_W-1:0]           put_idx,
    input  logic [WAY_W-1:0]           put_way,
    input  logic [TAG_W-1:0]           put_tag,
    input  logic                       kill_en,
    input  logic [IDX_W-1:0]           kill_idx
);
    localparam bit MULTI_WAY = (WAYS > 1);

    logic [DEPTH-1:0] e_vld;
    logic [SET_W-1:0] e_set [DEPTH];
    logic [WAY_W-1:0] e_way [DEPTH];
    logic [TAG_W-1:0] e_tag [DEPTH];
    logic [IDX_W-1:0] ptr_q;

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] tgt_idx;
    logic [IDX_W-1:0] wr_idx;

    // Lowest free slot wins; otherwise the rotation pointer names the oldest.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!e_vld[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        tgt_idx   = any_free ? free_idx : ptr_q;
        vic_valid = e_vld[tgt_idx];
        vic_set   = e_set[tgt_idx];
        vic_way   = e_way[tgt_idx];
        wr_idx    = put_inplace ? put_idx : tgt_idx;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_port
        always_comb begin
            q_hit[w] = 1'b0;
            q_idx[w] = '0;
            q_tag[w] = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (e_vld[i] && e_set[i] == qry_set &&
                    (!MULTI_WAY || e_way[i] == WAY_W'(w))) begin
                    q_hit[w] = 1'b1;
                    q_idx[w] = IDX_W'(i);
                    q_tag[w] = e_tag[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_vld <= '0;
            ptr_q <= '0;
        end else begin
            if (kill_en) e_vld[kill_idx] <= 1'b0;
            if (put_en) begin
                e_vld[wr_idx] <= 1'b1;
                if (!put_inplace && !any_free)
                    ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (put_en) begin
            e_set[wr_idx] <= qry_set;
            e_way[wr_idx] <= put_way;
            e_tag[wr_idx] <= put_tag;
        end
    end
endmodule

// File: rtl/tag_guard_array.sv
module tag_guard_array
    import tgr_pkg::*;
#(
    parameter int SETS     = 16,
    parameter int WAYS     = 4,
    parameter int TAG_W    = 16,
    parameter int RB_DEPTH = 8,
    localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int IDX_W   = (RB_DEPTH > 1) ? $clog2(RB_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [SET_W-1:0] req_set,
    input  logic [WAY_W-1:0] req_way,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_dirty,
    input  logic             inj_en,
    input  logic [SET_W-1:0] inj_set,
    input  logic [WAY_W-1:0] inj_way,
    input  logic [TAG_W-1:0] inj_mask,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic             rsp_fixed,
    output logic             rsp_uncorr,
    output logic             wb_req,
    output logic [SET_W-1:0] wb_set,
    output logic [WAY_W-1:0] wb_way
);
    state_e state_q, state_d;

    op_e              r_op;
    logic [SET_W-1:0] r_set;
    logic [WAY_W-1:0] r_way;
    logic [TAG_W-1:0] r_tag;
    logic             r_dirty;

    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_par, rd_vld, rd_dty, rd_cpy;
    logic [WAYS-1:0]            q_hit;
    logic [WAYS-1:0][IDX_W-1:0] q_idx;
    logic [WAYS-1:0][TAG_W-1:0] q_tag;
    logic                       vic_valid;
    logic [SET_W-1:0]           vic_set;
    logic [WAY_W-1:0]           vic_way;

    logic [WAYS-1:0]            perr, canfix, bad, match;
    logic [WAYS-1:0][TAG_W-1:0] ctag;
    logic [WAYS-1:0]            fix_en;
    logic                       eval, is_lookup, any_bad, any_match;
    logic [WAY_W-1:0]           hway;
    logic                       new_dirty, want_rep;
    logic                       ln_en, ln_vld, ln_dty, ln_cpy;
    logic [TAG_W-1:0]           ln_tag;
    logic                       dset_en, cset_en;
    logic                       put_en, put_inplace;
    logic [IDX_W-1:0]           put_idx;
    logic [WAY_W-1:0]           put_way;
    logic [TAG_W-1:0]           put_tag;
    logic                       kill_en;
    logic [IDX_W-1:0]           kill_idx;
    logic                       evict, ewb;
    rmode_e                     mode_e;

    assign mode_e    = rmode_e'(mode);
    assign ewb       = (mode_e == RM_DIRTY_WB) || (mode_e == RM_DIRTY_W2);
    assign req_ready = (state_q == ST_IDLE);
    assign eval      = (state_q == ST_EVAL);

    tgr_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(r_set),
        .rd_tag(rd_tag), .rd_par(rd_par), .rd_vld(rd_vld), .rd_dty(rd_dty), .rd_cpy(rd_cpy),
        .ln_en(ln_en), .ln_way(r_way), .ln_tag(ln_tag), .ln_vld(ln_vld), .ln_dty(ln_dty),
        .ln_cpy(ln_cpy), .fix_en(fix_en), .fix_tag(q_tag),
        .dset_en(dset_en), .cset_en(cset_en), .hit_way(hway),
        .vic_en(evict), .vic_clr_dty(ewb), .vic_set(vic_set), .vic_way(vic_way),
        .inj_en(inj_en), .inj_set(inj_set), .inj_way(inj_way), .inj_mask(inj_mask)
    );

    tgr_replica_buf #(
        .DEPTH(RB_DEPTH), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W),
        .IDX_W(IDX_W)
    ) u_rbuf (
        .clk(clk), .rst_n(rst_n), .qry_set(r_set),
        .q_hit(q_hit), .q_idx(q_idx), .q_tag(q_tag),
        .vic_valid(vic_valid), .vic_set(vic_set), .vic_way(vic_way),
        .put_en(put_en), .put_inplace(put_inplace), .put_idx(put_idx),
        .put_way(put_way), .put_tag(put_tag), .kill_en(kill_en), .kill_idx(kill_idx)
    );

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_op    <= OP_LOAD;
            r_set   <= '0;
            r_way   <= '0;
            r_tag   <= '0;
            r_dirty <= 1'b0;
        end else if (req_ready && req_valid) begin
            r_op    <= op_e'(req_op);
            r_set   <= req_set;
            r_way   <= req_way;
            r_tag   <= req_tag;
            r_dirty <= req_dirty;
        end
    end

    // Parity check, repair choice and hit search over the addressed set
    always_comb begin
        is_lookup = eval && (r_op == OP_LOAD || r_op == OP_STORE);
        for (int w = 0; w < WAYS; w++) begin
            perr[w]   = rd_vld[w] && ((^rd_tag[w]) != rd_par[w]);
            canfix[w] = perr[w] && rd_cpy[w] && q_hit[w];
            bad[w]    = perr[w] && !canfix[w];
            ctag[w]   = canfix[w] ? q_tag[w] : rd_tag[w];
            match[w]  = rd_vld[w] && (ctag[w] == r_tag);
        end
        any_bad   = |bad;
        any_match = 1'b0;
        hway      = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                any_match = 1'b1;
                hway      = WAY_W'(w);
            end
        end
        fix_en = (is_lookup && !any_bad) ? canfix : '0;
    end

    // State updates of the EVAL cycle
    always_comb begin
        ln_en       = 1'b0;
        ln_tag      = r_tag;
        ln_vld      = 1'b0;
        ln_dty      = 1'b0;
        ln_cpy      = 1'b0;
        dset_en     = 1'b0;
        cset_en     = 1'b0;
        put_en      = 1'b0;
        put_inplace = 1'b0;
        put_idx     = q_idx[r_way];
        put_way     = r_way;
        put_tag     = r_tag;
        kill_en     = 1'b0;
        kill_idx    = q_idx[r_way];
        new_dirty   = rd_dty[hway] || (r_op == OP_STORE);
        want_rep    = 1'b0;
        if (is_lookup && !any_bad && any_match) begin
            want_rep = (mode_e == RM_ALL) || new_dirty;
            dset_en  = (r_op == OP_STORE);
            if (want_rep && !rd_cpy[hway]) begin
                put_en  = 1'b1;
                put_way = hway;
                put_tag = ctag[hway];
                cset_en = 1'b1;
            end
        end else if (eval && r_op == OP_FILL) begin
            want_rep    = (mode_e == RM_ALL) || r_dirty;
            ln_en       = 1'b1;
            ln_vld      = 1'b1;
            ln_dty      = r_dirty;
            ln_cpy      = want_rep;
            put_en      = want_rep;
            put_inplace = q_hit[r_way];
            kill_en     = q_hit[r_way] && !want_rep;
        end else if (eval && r_op == OP_INVAL) begin
            ln_en   = 1'b1;
            kill_en = q_hit[r_way];
        end
        evict = put_en && !put_inplace && vic_valid;
    end

    // FSM: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // FSM: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_fixed  <= 1'b0;
            rsp_uncorr <= 1'b0;
            wb_req     <= 1'b0;
            wb_set     <= '0;
            wb_way     <= '0;
        end else begin
            rsp_valid  <= eval;
            rsp_hit    <= is_lookup && !any_bad && any_match;
            rsp_way    <= hway;
            rsp_fixed  <= |fix_en;
            rsp_uncorr <= is_lookup && any_bad;
            wb_req     <= evict && ewb;
            wb_set     <= vic_set;
            wb_way     <= vic_way;
        end
    end
endmodule

// File: rtl/tgr_checker.sv
module tgr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_fixed,
    input logic       rsp_uncorr,
    input logic       wb_req
);
    AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid); // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_UNCORR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncorr |-> !rsp_hit); // R4
    AST_FIX_UNCORR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fixed && rsp_uncorr)); // R11
    AST_FLAGS_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_fixed || rsp_uncorr || wb_req) |-> rsp_valid); // R11
    AST_WB_ONLY_EWB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> $past(mode[1])); // R9
endmodule

bind tag_guard_array tgr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fixed(rsp_fixed),
    .rsp_uncorr(rsp_uncorr), .wb_req(wb_req)
);

// File: tb/tb_tag_guard_array.sv
module tb_tag_guard_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [3:0]  req_set = '0;
    logic [1:0]  req_way = '0;
    logic [15:0] req_tag = '0;
    logic        req_dirty = 1'b0;
    logic        inj_en = 1'b0;
    logic [3:0]  inj_set = '0;
    logic [1:0]  inj_way = '0;
    logic [15:0] inj_mask = '0;
    logic        rsp_valid, rsp_hit, rsp_fixed, rsp_uncorr, wb_req;
    logic [1:0]  rsp_way, wb_way;
    logic [3:0]  wb_set;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tag_guard_array dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_set(req_set), .req_way(req_way), .req_tag(req_tag),
        .req_dirty(req_dirty), .inj_en(inj_en), .inj_set(inj_set), .inj_way(inj_way),
        .inj_mask(inj_mask), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_fixed(rsp_fixed), .rsp_uncorr(rsp_uncorr), .wb_req(wb_req), .wb_set(wb_set),
        .wb_way(wb_way)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  op;
        logic [3:0]  set;
        logic [1:0]  way;
        logic [15:0] tag;
        logic        dirty;
        logic [15:0] inj;
        logic        e_hit;
        logic [1:0]  e_way;
        logic        e_fix;
        logic        e_unc;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd2, 4'd1, 2'd0, 16'hA001, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0}, // R5 fill
        '{2'd0, 2'd0, 4'd1, 2'd0, 16'hA001, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b0, 1'b0}, // R2 hit
        '{2'd0, 2'd0, 4'd1, 2'd0, 16'hBEEF, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0}, // R2 miss
        '{2'd0, 2'd0, 4'd1, 2'd0, 16'hA001, 1'b0, 16'h0004, 1'b1, 2'd0, 1'b1, 1'b0}, // R3 repair
        '{2'd0, 2'd0, 4'd1, 2'd0, 16'hA001, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b0, 1'b0}, // R3 kept
        '{2'd1, 2'd2, 4'd2, 2'd1, 16'hA002, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0}, // R6 clean
        '{2'd1, 2'd0, 4'd2, 2'd1, 16'hA002, 1'b0, 16'h0100, 1'b0, 2'd0, 1'b0, 1'b1}, // R6 R4
        '{2'd1, 2'd0, 4'd2, 2'd1, 16'hA002, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b1}, // R4 again
        '{2'd1, 2'd2, 4'd2, 2'd1, 16'hA002, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0}, // refill
        '{2'd1, 2'd0, 4'd2, 2'd1, 16'hA002, 1'b0, 16'h0000, 1'b1, 2'd1, 1'b0, 1'b0}, // R2
        '{2'd1, 2'd1, 4'd2, 2'd1, 16'hA002, 1'b0, 16'h0000, 1'b1, 2'd1, 1'b0, 1'b0}, // R6 store
        '{2'd1, 2'd0, 4'd2, 2'd1, 16'hA002, 1'b0, 16'h0001, 1'b1, 2'd1, 1'b1, 1'b0}, // R6 replica
        '{2'd1, 2'd2, 4'd1, 2'd0, 16'hC001, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0}, // R7 refill
        '{2'd1, 2'd0, 4'd1, 2'd0, 16'hC001, 1'b0, 16'h0010, 1'b0, 2'd0, 1'b0, 1'b1}, // R7 dropped
        '{2'd1, 2'd3, 4'd2, 2'd1, 16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0}, // R7 inval
        '{2'd1, 2'd0, 4'd2, 2'd1, 16'hA002, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0}  // R7 gone
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic inject(input logic [3:0] s, input logic [1:0] w, input logic [15:0] m);
        @(negedge clk);
        inj_en = 1'b1; inj_set = s; inj_way = w; inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    // Issue one request; returns at the falling edge of the response cycle.
    task automatic run_op(input logic [1:0] m, input logic [1:0] op, input logic [3:0] s,
                          input logic [1:0] w, input logic [15:0] t, input logic d);
        @(negedge clk);
        mode = m; req_valid = 1'b1; req_op = op; req_set = s; req_way = w;
        req_tag = t; req_dirty = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "ready while busy", int'(req_ready), 0);
        @(negedge clk);
        check("R1", "rsp_valid", int'(rsp_valid), 1);
    endtask

    function automatic logic [15:0] tg(input int s, input int w);
        return 16'h5000 | 16'(s << 4) | 16'(w);
    endfunction

    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        apply_reset();
        @(negedge clk);
        check("R1", "ready after reset", int'(req_ready), 1);
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        check("R9", "wb_req after reset", int'(wb_req), 0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].inj != 16'h0) inject(TBL[i].set, TBL[i].way, TBL[i].inj);
            run_op(TBL[i].mode, TBL[i].op, TBL[i].set, TBL[i].way, TBL[i].tag, TBL[i].dirty);
            check("R2", $sformatf("vec %0d hit", i), int'(rsp_hit), int'(TBL[i].e_hit));
            if (TBL[i].e_hit) check("R2", $sformatf("vec %0d way", i), int'(rsp_way), int'(TBL[i].e_way));
            check("R3", $sformatf("vec %0d fixed", i), int'(rsp_fixed), int'(TBL[i].e_fix));
            check("R4", $sformatf("vec %0d uncorr", i), int'(rsp_uncorr), int'(TBL[i].e_unc));
            check("R9", $sformatf("vec %0d wb idle", i), int'(wb_req), 0);
            @(negedge clk);
            check("R1", $sformatf("vec %0d rsp one cycle", i), int'(rsp_valid), 0);
        end

        // FIFO+ replacement with forced write-back
        apply_reset();
        for (int s = 0; s < 8; s++) begin
            run_op(2'd2, 2'd2, 4'(s), 2'd2, tg(s, 2), 1'b1);
            check("R8", "no wb while free slots", int'(wb_req), 0);
        end
        run_op(2'd2, 2'd2, 4'd8, 2'd2, tg(8, 2), 1'b1);
        check("R9", "wb on displacement", int'(wb_req), 1);
        check("R8", "oldest set displaced", int'(wb_set), 0);
        check("R8", "oldest way displaced", int'(wb_way), 2);
        @(negedge clk);
        check("R9", "wb one cycle", int'(wb_req), 0);
        inject(4'd0, 2'd2, 16'h0080);
        run_op(2'd2, 2'd0, 4'd0, 2'd2, tg(0, 2), 1'b0);
        check("R8", "displaced copy flag cleared", int'(rsp_uncorr), 1);
        run_op(2'd2, 2'd2, 4'd9, 2'd2, tg(9, 2), 1'b1);
        check("R8", "rotation next set", int'(wb_set), 1);
        check("R9", "rotation wb", int'(wb_req), 1);
        run_op(2'd2, 2'd3, 4'd4, 2'd2, 16'h0, 1'b0);
        check("R7", "inval no wb", int'(wb_req), 0);
        run_op(2'd2, 2'd2, 4'd10, 2'd2, tg(10, 2), 1'b1);
        check("R8", "freed slot reused first", int'(wb_req), 0);
        run_op(2'd2, 2'd2, 4'd11, 2'd2, tg(11, 2), 1'b1);
        check("R8", "rotation resumes set", int'(wb_set), 2);
        check("R9", "rotation resumes wb", int'(wb_req), 1);

        // Repair and allocation with displacement in one response
        run_op(2'd2, 2'd2, 4'd5, 2'd0, 16'h7777, 1'b0);
        check("R6", "clean fill no wb", int'(wb_req), 0);
        inject(4'd5, 2'd2, 16'h0040);
        run_op(2'd2, 2'd1, 4'd5, 2'd0, 16'h7777, 1'b0);
        check("R10", "store hit", int'(rsp_hit), 1);
        check("R10", "store way", int'(rsp_way), 0);
        check("R10", "other way repaired", int'(rsp_fixed), 1);
        check("R10", "displacement wb", int'(wb_req), 1);
        check("R10", "displaced set", int'(wb_set), 3);
        check("R10", "displaced way", int'(wb_way), 2);
        run_op(2'd2, 2'd0, 4'd5, 2'd2, tg(5, 2), 1'b0);
        check("R10", "repaired way hits", int'(rsp_hit), 1);
        check("R10", "repaired way index", int'(rsp_way), 2);
        check("R3", "repair persisted", int'(rsp_fixed), 0);

        // Mode 1 never requests write-back even when full
        run_op(2'd1, 2'd2, 4'd12, 2'd2, tg(12, 2), 1'b1);
        check("R9", "no wb in mode 1", int'(wb_req), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule